// File: doc/BRIEF.md
# Table Transfer Bridge Between Data Side and Byte Program Store

This block moves single bytes between a CPU's 8-bit data side and a byte-organised program store. Software loads a wide table pointer and fills or reads back a one-byte holding latch. A read request fetches the byte at the pointer into the latch. A write request sends the latch byte either into the internal program store or out through an external write port. Instructions span two or four bytes of the store, so every transfer moves exactly one byte.

The internal store is modelled as one-time-programmable. A write can only turn stored ones into zeros, so the new content is the bitwise AND of the old byte and the latch. Internal writes are allowed only after software sets a sticky long-write enable. Software cannot clear this enable. Only the block reset, which stands for a power-on or master-clear reset, returns it to zero. While the enable is zero, every write goes to the external port.

Top module: `tbl_bridge`

## Requirements
- R1: After reset, `latch_rdata` is 0x00, `lwen`, `rd_busy`, `rd_done` and `ext_wr_stb` are 0, and every internal store byte reads 0xFF (erased).
- R2: `ptr_load` loads `ptr_wdata` into the PTR_W-bit pointer, which is visible on `ptr_rdata` after the next edge. Internal store accesses use only the low log2(PM_DEPTH) pointer bits. Higher bits are ignored, so 0x100005 and 0x000005 name the same byte when PM_DEPTH is 256.
- R3: A read request accepted while idle raises `rd_busy` for the next cycle. On the edge after that, the latch holds the store byte at the pointer and `rd_done` is high for exactly one cycle.
- R4: `latch_wr` loads `latch_wdata` into the latch, visible on `latch_rdata` after the next edge. On the edge that completes a read, the fetched byte wins over `latch_wr`.
- R5: A software write of 1 to the long-write enable sets `lwen`. A software write of 0 has no effect. Once set, `lwen` stays 1 until `rst`.
- R6: A write request accepted while `lwen` is 0 produces `ext_wr_stb` high for one cycle, starting after the next edge. During that cycle `ext_wr_addr` is the full pointer and `ext_wr_data` is the latch value at the time of the request. The internal store is left unchanged.
- R7: A write request accepted while `lwen` is 1 replaces the internal store byte with (old AND latch) and raises no external strobe. A stored 0 bit never returns to 1.
- R8: Requests are accepted only while `rd_busy` is 0. When `rd_req` and `wr_req` arrive together, the read is taken and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on / master clear) |
| ptr_load | input | 1 | Load the table pointer |
| ptr_wdata | input | PTR_W | New pointer value |
| ptr_rdata | output | PTR_W | Current pointer |
| latch_wr | input | 1 | Data-side write of the latch |
| latch_wdata | input | 8 | Byte written into the latch |
| latch_rdata | output | 8 | Current latch byte |
| lwen_wr | input | 1 | Software write of the long-write enable |
| lwen_wdata | input | 1 | Value written to the enable |
| lwen | output | 1 | Long-write enable state |
| rd_req | input | 1 | Request a table read |
| wr_req | input | 1 | Request a table write |
| rd_busy | output | 1 | Read fetch in progress |
| rd_done | output | 1 | One-cycle pulse: latch holds the read byte |
| ext_wr_stb | output | 1 | One-cycle external write strobe |
| ext_wr_addr | output | PTR_W | External write address |
| ext_wr_data | output | 8 | External write byte |

## Verification
Reads are tried on erased bytes, on bytes cleared by earlier internal writes, and through a pointer whose high bits are set. Together these separate correct address truncation from a wrong index. Internal writes are applied as a sequence of 0xA5, then 0x3C, then 0xFF to one byte. The expected results 0xA5, 0x24 and 0x24 separate AND merging from plain overwrite or OR. The same write request is issued with the enable clear and with it set, which shows whether routing between the external port and the internal store follows the enable. Software writes of 0 are tried against a set enable, and a request collision is used to confirm that the write is dropped.

// File: rtl/tbl_pkg.sv
package tbl_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } rd_state_e;

    // One-cycle decisions taken by the controller
    typedef struct packed {
        logic go_rd;
        logic go_wr_int;
        logic go_wr_ext;
    } xfer_t;

    // One-time-programmable merge: bits may only fall from 1 to 0
    function automatic byte_t otp_merge(input byte_t old_b, input byte_t new_b);
        return old_b & new_b;
    endfunction

    // Sticky enable: software can set, never clear
    function automatic logic sticky_next(input logic cur, input logic wr, input logic wdata);
        return cur | (wr & wdata);
    endfunction

endpackage

// File: rtl/tbl_ctrl.sv
module tbl_ctrl
    import tbl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_req,
    input  logic  wr_req,
    input  logic  lwen_wr,
    input  logic  lwen_wdata,
    output xfer_t xfer,
    output logic  fetch,
    output logic  done,
    output logic  lwen
);

    rd_state_e state_q;
    logic      done_q;
    logic      lwen_q;
    logic      idle;
    logic      go_wr;

    assign idle  = (state_q == ST_IDLE);
    assign go_wr = idle & wr_req & ~rd_req;

    always_comb begin
        xfer           = '0;
        xfer.go_rd     = idle & rd_req;
        xfer.go_wr_int = go_wr & lwen_q;
        xfer.go_wr_ext = go_wr & ~lwen_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            lwen_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_q <= xfer.go_rd ? ST_FETCH : ST_IDLE;
                ST_FETCH: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
            done_q <= (state_q == ST_FETCH);
            lwen_q <= sticky_next(lwen_q, lwen_wr, lwen_wdata);
        end
    end

    assign fetch = (state_q == ST_FETCH);
    assign done  = done_q;
    assign lwen  = lwen_q;

endmodule

// File: rtl/tbl_pmem.sv
module tbl_pmem
    import tbl_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_go,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    output byte_t         rd_data
);

    byte_t         mem [DEPTH];
    logic [AW-1:0] rd_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (wr_go) begin
            mem[wr_addr] <= otp_merge(mem[wr_addr], wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_addr_q <= '0;
        end else if (rd_go) begin
            rd_addr_q <= rd_addr;
        end
    end

    assign rd_data = mem[rd_addr_q];

endmodule

// File: rtl/tbl_ext_port.sv
module tbl_ext_port
    import tbl_pkg::*;
#(
    parameter int PTR_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [PTR_W-1:0] addr,
    input  byte_t            data,
    output logic             stb,
    output logic [PTR_W-1:0] addr_q,
    output byte_t            data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stb    <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            stb <= go;
            if (go) begin
                addr_q <= addr;
                data_q <= data;
            end
        end
    end

endmodule

// File: rtl/tbl_bridge.sv
module tbl_bridge
    import tbl_pkg::*;
#(
    parameter int PTR_W    = 21,
    parameter int PM_DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_load,
    input  logic [PTR_W-1:0] ptr_wdata,
    output logic [PTR_W-1:0] ptr_rdata,
    input  logic             latch_wr,
    input  logic [7:0]       latch_wdata,
    output logic [7:0]       latch_rdata,
    input  logic             lwen_wr,
    input  logic             lwen_wdata,
    output logic             lwen,
    input  logic             rd_req,
    input  logic             wr_req,
    output logic             rd_busy,
    output logic             rd_done,
    output logic             ext_wr_stb,
    output logic [PTR_W-1:0] ext_wr_addr,
    output logic [7:0]       ext_wr_data
);

    localparam int AW = (PM_DEPTH > 1) ? $clog2(PM_DEPTH) : 1;

    logic [PTR_W-1:0] ptr_q;
    byte_t            latch_q;
    byte_t            pm_rd_data;
    xfer_t            xfer;
    logic             fetch;
    logic [AW-1:0]    pm_index;

    assign pm_index = ptr_q[AW-1:0];

    tbl_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .lwen_wr    (lwen_wr),
        .lwen_wdata (lwen_wdata),
        .xfer       (xfer),
        .fetch      (fetch),
        .done       (rd_done),
        .lwen       (lwen)
    );

    tbl_pmem #(.DEPTH(PM_DEPTH)) u_pmem (
        .clk     (clk),
        .rst     (rst),
        .rd_go   (xfer.go_rd),
        .rd_addr (pm_index),
        .wr_go   (xfer.go_wr_int),
        .wr_addr (pm_index),
        .wr_data (latch_q),
        .rd_data (pm_rd_data)
    );

    tbl_ext_port #(.PTR_W(PTR_W)) u_ext (
        .clk    (clk),
        .rst    (rst),
        .go     (xfer.go_wr_ext),
        .addr   (ptr_q),
        .data   (latch_q),
        .stb    (ext_wr_stb),
        .addr_q (ext_wr_addr),
        .data_q (ext_wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= ptr_wdata;
        end
    end

    // Read fill has priority over a data-side latch write
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (fetch) begin
            latch_q <= pm_rd_data;
        end else if (latch_wr) begin
            latch_q <= latch_wdata;
        end
    end

    assign ptr_rdata   = ptr_q;
    assign latch_rdata = latch_q;
    assign rd_busy     = fetch;

endmodule

// File: rtl/tbl_bridge_chk.sv
module tbl_bridge_chk #(
    parameter int PTR_W = 21
) (
    input logic             clk,
    input logic             rst,
    input logic [PTR_W-1:0] ptr_rdata,
    input logic [7:0]       latch_rdata,
    input logic             lwen_wr,
    input logic             lwen_wdata,
    input logic             lwen,
    input logic             rd_req,
    input logic             wr_req,
    input logic             rd_busy,
    input logic             rd_done,
    input logic             ext_wr_stb,
    input logic [PTR_W-1:0] ext_wr_addr,
    input logic [7:0]       ext_wr_data
);

    AST_LWEN_STICKY: assert property (@(posedge clk) disable iff (rst)
        lwen |=> lwen); // R5

    AST_LWEN_SET: assert property (@(posedge clk) disable iff (rst)
        (lwen_wr && lwen_wdata) |=> lwen); // R5

    AST_RD_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_busy) |=> rd_busy); // R3

    AST_RD_FINISH: assert property (@(posedge clk) disable iff (rst)
        rd_busy |=> (rd_done && !rd_busy)); // R3

    AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> $past(rd_busy)); // R3

    AST_EXT_GATED: assert property (@(posedge clk) disable iff (rst)
        ext_wr_stb |-> $past(wr_req && !rd_req && !rd_busy && !lwen)); // R6

    AST_EXT_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        ext_wr_stb |-> (ext_wr_data == $past(latch_rdata) &&
                        ext_wr_addr == $past(ptr_rdata))); // R6

    AST_NO_EXT_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_req && lwen) |=> !ext_wr_stb); // R7

    AST_BUSY_BLOCKS_WR: assert property (@(posedge clk) disable iff (rst)
        rd_busy |=> !ext_wr_stb); // R8

endmodule

bind tbl_bridge tbl_bridge_chk #(.PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ptr_rdata   (ptr_rdata),
    .latch_rdata (latch_rdata),
    .lwen_wr     (lwen_wr),
    .lwen_wdata  (lwen_wdata),
    .lwen        (lwen),
    .rd_req      (rd_req),
    .wr_req      (wr_req),
    .rd_busy     (rd_busy),
    .rd_done     (rd_done),
    .ext_wr_stb  (ext_wr_stb),
    .ext_wr_addr (ext_wr_addr),
    .ext_wr_data (ext_wr_data)
);

// File: tb/tbl_bridge_bench.sv
module tbl_bridge_bench;

    localparam int PTR_W = 21;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ptr_load = 1'b0;
    logic [PTR_W-1:0] ptr_wdata = '0;
    logic [PTR_W-1:0] ptr_rdata;
    logic             latch_wr = 1'b0;
    logic [7:0]       latch_wdata = '0;
    logic [7:0]       latch_rdata;
    logic             lwen_wr = 1'b0;
    logic             lwen_wdata = 1'b0;
    logic             lwen;
    logic             rd_req = 1'b0;
    logic             wr_req = 1'b0;
    logic             rd_busy;
    logic             rd_done;
    logic             ext_wr_stb;
    logic [PTR_W-1:0] ext_wr_addr;
    logic [7:0]       ext_wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tbl_bridge #(.PTR_W(PTR_W), .PM_DEPTH(256)) u_tbl_bridge (
        .clk (clk), .rst (rst),
        .ptr_load (ptr_load), .ptr_wdata (ptr_wdata), .ptr_rdata (ptr_rdata),
        .latch_wr (latch_wr), .latch_wdata (latch_wdata), .latch_rdata (latch_rdata),
        .lwen_wr (lwen_wr), .lwen_wdata (lwen_wdata), .lwen (lwen),
        .rd_req (rd_req), .wr_req (wr_req), .rd_busy (rd_busy), .rd_done (rd_done),
        .ext_wr_stb (ext_wr_stb), .ext_wr_addr (ext_wr_addr), .ext_wr_data (ext_wr_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic apply_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_ptr(input logic [PTR_W-1:0] v);
        @(negedge clk); ptr_load = 1'b1; ptr_wdata = v;
        @(negedge clk); ptr_load = 1'b0;
        chk("R2 pointer load", 32'(ptr_rdata), 32'(v));
    endtask

    task automatic load_latch(input logic [7:0] v);
        @(negedge clk); latch_wr = 1'b1; latch_wdata = v;
        @(negedge clk); latch_wr = 1'b0;
        chk("R4 latch write", 32'(latch_rdata), 32'(v));
    endtask

    task automatic write_lwen(input logic v);
        @(negedge clk); lwen_wr = 1'b1; lwen_wdata = v;
        @(negedge clk); lwen_wr = 1'b0;
    endtask

    // Read with optional simultaneous write request (R8 collision)
    task automatic do_read(input logic [7:0] exp, input logic with_wr, input string tag);
        @(negedge clk); rd_req = 1'b1; wr_req = with_wr;
        @(negedge clk); rd_req = 1'b0; wr_req = 1'b0;
        chk({tag, " busy"}, 32'(rd_busy), 32'd1);
        chk({tag, " early done"}, 32'(rd_done), 32'd0);
        chk({tag, " no strobe"}, 32'(ext_wr_stb), 32'd0);
        @(negedge clk);
        chk({tag, " done"}, 32'(rd_done), 32'd1);
        chk({tag, " data"}, 32'(latch_rdata), 32'(exp));
        @(negedge clk);
        chk({tag, " done pulse ends"}, 32'(rd_done), 32'd0);
    endtask

    task automatic do_write(input logic exp_stb, input logic [PTR_W-1:0] exp_addr,
                            input logic [7:0] exp_data, input string tag);
        @(negedge clk); wr_req = 1'b1;
        @(negedge clk); wr_req = 1'b0;
        chk({tag, " strobe"}, 32'(ext_wr_stb), 32'(exp_stb));
        if (exp_stb) begin
            chk({tag, " addr"}, 32'(ext_wr_addr), 32'(exp_addr));
            chk({tag, " data"}, 32'(ext_wr_data), 32'(exp_data));
        end
        @(negedge clk);
        chk({tag, " strobe ends"}, 32'(ext_wr_stb), 32'd0);
    endtask

    task automatic t_reset_state();
        apply_reset();
        @(negedge clk);
        chk("R1 latch", 32'(latch_rdata), 32'h00);
        chk("R1 lwen", 32'(lwen), 32'd0);
        chk("R1 busy", 32'(rd_busy), 32'd0);
        chk("R1 done", 32'(rd_done), 32'd0);
        chk("R1 strobe", 32'(ext_wr_stb), 32'd0);
        load_ptr(21'h000010);
        do_read(8'hFF, 1'b0, "R1 erased byte R3");
    endtask

    task automatic t_ext_write();
        load_ptr(21'h1ABCDE);
        load_latch(8'h5A);
        do_write(1'b1, 21'h1ABCDE, 8'h5A, "R6 external");
        do_read(8'hFF, 1'b0, "R6 internal untouched");
    endtask

    task automatic t_lwen();
        write_lwen(1'b0);
        chk("R5 zero write while clear", 32'(lwen), 32'd0);
        write_lwen(1'b1);
        chk("R5 set", 32'(lwen), 32'd1);
        write_lwen(1'b0);
        chk("R5 zero write ignored", 32'(lwen), 32'd1);
    endtask

    task automatic t_int_write();
        load_ptr(21'h000005);
        load_latch(8'hA5);
        do_write(1'b0, '0, '0, "R7 internal no strobe");
        do_read(8'hA5, 1'b0, "R7 first program");
        load_latch(8'h3C);
        do_write(1'b0, '0, '0, "R7 second no strobe");
        do_read(8'h24, 1'b0, "R7 AND merge");
        load_latch(8'hFF);
        do_write(1'b0, '0, '0, "R7 third no strobe");
        do_read(8'h24, 1'b0, "R7 zero stays zero");
        load_ptr(21'h100005);
        do_read(8'h24, 1'b0, "R2 high bits ignored");
    endtask

    task automatic t_collision();
        load_ptr(21'h000007);
        load_latch(8'h00);
        do_read(8'hFF, 1'b1, "R8 read wins");
        do_read(8'hFF, 1'b0, "R8 write dropped");
        // write request raised while the fetch is busy
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0; wr_req = 1'b1;
        chk("R8 busy during wr", 32'(rd_busy), 32'd1);
        @(negedge clk); wr_req = 1'b0;
        chk("R3 done after busy", 32'(rd_done), 32'd1);
        @(negedge clk);
        do_read(8'hFF, 1'b0, "R8 busy write dropped");
    endtask

    task automatic t_reset_again();
        apply_reset();
        @(negedge clk);
        chk("R5 reset clears lwen", 32'(lwen), 32'd0);
        load_ptr(21'h000005);
        do_read(8'hFF, 1'b0, "R1 reset erases store");
    endtask

    initial begin
        t_reset_state();
        t_ext_write();
        t_lwen();
        t_int_write();
        t_collision();
        t_reset_again();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule